// File: doc/BRIEF.md
# Transmit FIFO DMA Request Generator

This block sits next to a UART transmit FIFO and drives a level DMA request that tells a system DMA controller when to refill the FIFO from memory. It keeps its own count of the FIFO fill level from the FIFO's write and read strobes, so it needs no other status from the FIFO.

There are two ways of deciding the request. In burst mode the request opens when the fill level has fallen to a small programmed low-water mark. It then stays open until the DMA has written exactly one burst of bytes, where the burst length is a programmed value. After that it stays closed until transmission has drained the FIFO back down to the mark. In space mode the request simply follows free space: it is high whenever at least one burst of bytes would fit. Burst mode is used only when its select bit is set and the low-water mark plus the burst length fits in the FIFO. Otherwise the block falls back to space mode, so a burst can never overrun the FIFO.

Top module: `tx_dma_req_gen`

## Requirements
- R1: While reset is low, `dma_req` is 0 and the tracked fill level is cleared to 0.
- R2: On each clock edge the tracked level rises by one for a write strobe while the level is below `DEPTH`, and falls by one for a read strobe while the level is above 0. Both tests use the level before the edge. A read when empty and a write when full have no effect.
- R3: Burst mode is in force when `burst_sel` is 1 and `low_mark + burst_len <= DEPTH`. At equality it is still burst mode.
- R4: In burst mode with `dma_en` high and `burst_len` nonzero, a closed request opens on the edge where the new level is at or below `low_mark`. This includes an empty FIFO right after reset.
- R5: In burst mode an open request closes on the edge that accepts the `burst_len`-th write since it opened. Read strobes do not close it.
- R6: After a burst completes, the request stays low until reads bring the level to `low_mark` or below.
- R7: In space mode, `dma_req` is 1 exactly when `DEPTH` minus the new level is at least `burst_len`, with `dma_en` high.
- R8: When `burst_sel` is 1 but `low_mark + burst_len > DEPTH`, the block behaves as in space mode (R7).
- R9: A clock edge that samples `dma_en` low clears `dma_req` and the burst write count. A burst that opens later needs a full `burst_len` writes to close.
- R10: `dma_req` is registered. It changes only on the clock edge that samples the strobe or setting that caused the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_wr | input | 1 | Transmit FIFO write strobe (DMA fill) |
| fifo_rd | input | 1 | Transmit FIFO read strobe (serializer drain) |
| burst_sel | input | 1 | 1 selects burst mode, 0 selects space mode |
| dma_en | input | 1 | DMA enable |
| low_mark | input | MARK_W (3) | Low-water mark for burst mode |
| burst_len | input | LVL_W (7) | Burst length; also the free-space trigger in space mode |
| dma_req | output | 1 | Level DMA request |

## Verification
On every cycle the assertions check four things. The request is low after any edge that sampled the enable low. The tracked level never leaves 0 to `DEPTH`. In burst mode an enabled request only opens at or below the mark, and only closes on an edge that carried a write. Space-mode output matches free space. The exact burst length cannot be seen from a single cycle, so directed scenarios show it. They also show that the burst count restarts after a disable, and that a burst request is held through reads. The boundary where mark plus burst equals the depth, against one more, is also checked by scenario.

// File: rtl/tx_dma_req_gen.sv
module tx_dma_req_gen #(
  parameter int DEPTH  = 64,
  parameter int MARK_W = 3,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_wr,
  input  logic              fifo_rd,
  input  logic              burst_sel,
  input  logic              dma_en,
  input  logic [MARK_W-1:0] low_mark,
  input  logic [LVL_W-1:0]  burst_len,
  output logic              dma_req
);

  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);
  localparam logic [LVL_W:0]   DEPTH_S = (LVL_W+1)'(DEPTH);

  logic [LVL_W-1:0] level, level_nxt, burst_cnt, free_nxt;
  logic             wr_ok, rd_ok, use_burst;
  logic [LVL_W:0]   span;

  assign wr_ok     = fifo_wr && (level < DEPTH_L);
  assign rd_ok     = fifo_rd && (level != '0);
  assign level_nxt = level + LVL_W'(wr_ok) - LVL_W'(rd_ok);
  assign free_nxt  = DEPTH_L - level_nxt;
  assign span      = {1'b0, burst_len} + (LVL_W+1)'(low_mark);
  assign use_burst = burst_sel && (span <= DEPTH_S);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level     <= '0;
      burst_cnt <= '0;
      dma_req   <= 1'b0;
    end else begin
      level <= level_nxt;
      if (!dma_en) begin
        dma_req   <= 1'b0;
        burst_cnt <= '0;
      end else if (!use_burst) begin
        dma_req   <= (free_nxt >= burst_len);
        burst_cnt <= '0;
      end else if (dma_req) begin
        if (wr_ok) begin
          if (burst_cnt + 1'b1 >= burst_len) begin
            dma_req   <= 1'b0;
            burst_cnt <= '0;
          end else begin
            burst_cnt <= burst_cnt + 1'b1;
          end
        end
      end else begin
        dma_req   <= (burst_len != '0) && (level_nxt <= LVL_W'(low_mark));
        burst_cnt <= '0;
      end
    end
  end

endmodule

module tx_dma_req_gen_chk #(
  parameter int DEPTH  = 64,
  parameter int MARK_W = 3,
  parameter int LVL_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_wr,
  input logic              dma_en,
  input logic              use_burst,
  input logic [MARK_W-1:0] low_mark,
  input logic [LVL_W-1:0]  burst_len,
  input logic [LVL_W-1:0]  level,
  input logic              dma_req
);

  p_off_when_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !dma_req);

  p_level_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  p_open_at_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dma_req) && $past(use_burst) && $past(dma_en)) |-> (level <= LVL_W'($past(low_mark))));

  p_close_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dma_req) && $past(use_burst) && $past(dma_en)) |-> $past(fifo_wr));

  p_space_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_burst && dma_en) |=> (dma_req == ((LVL_W'(DEPTH) - level) >= $past(burst_len))));

endmodule

bind tx_dma_req_gen tx_dma_req_gen_chk #(
  .DEPTH(DEPTH), .MARK_W(MARK_W), .LVL_W(LVL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .dma_en(dma_en),
  .use_burst(use_burst), .low_mark(low_mark), .burst_len(burst_len),
  .level(level), .dma_req(dma_req)
);

// File: tb/tx_dma_req_gen_tb.sv
`timescale 1ns/1ps
module tx_dma_req_gen_tb_top;
  localparam int DEPTH = 64;
  localparam int LVL_W = 7;

  logic clk = 0, rst_n = 0, fifo_wr = 0, fifo_rd = 0, burst_sel = 0, dma_en = 0;
  logic [2:0] low_mark = 0;
  logic [LVL_W-1:0] burst_len = 0;
  logic dma_req;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  tx_dma_req_gen #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
    .burst_sel(burst_sel), .dma_en(dma_en), .low_mark(low_mark),
    .burst_len(burst_len), .dma_req(dma_req)
  );

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FIFO-DMA FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc(logic w, logic r);
    fifo_wr = w; fifo_rd = r;
    @(negedge clk);
    fifo_wr = 0; fifo_rd = 0;
  endtask

  task automatic writes(int n);
    for (int i = 0; i < n; i++) cyc(1, 0);
  endtask

  task automatic reads(int n);
    for (int i = 0; i < n; i++) cyc(0, 1);
  endtask

  task automatic do_reset(logic sel, logic en, int mark, int blen);
    rst_n = 0; burst_sel = sel; dma_en = en;
    low_mark = 3'(mark); burst_len = LVL_W'(blen);
    repeat (2) @(negedge clk);
    chk("R1", dma_req, 1'b0, "request during reset");
    rst_n = 1;
  endtask

  task automatic t_level_tracking;
    do_reset(0, 1, 0, 64);
    cyc(0, 0);  chk("R7", dma_req, 1'b1, "empty fifo, full burst fits");
    cyc(0, 1);  chk("R2", dma_req, 1'b1, "read when empty ignored");
    cyc(1, 0);  chk("R2", dma_req, 1'b0, "one write raises level");
    cyc(1, 1);  chk("R2", dma_req, 1'b0, "write+read keeps level");
    cyc(0, 1);  chk("R2", dma_req, 1'b1, "read back to empty");
  endtask

  task automatic t_burst;
    do_reset(1, 1, 3, 8);
    cyc(0, 0);  chk("R4", dma_req, 1'b1, "opens on empty fifo");
    writes(7);  chk("R5", dma_req, 1'b1, "held before last burst write");
    fifo_wr = 1; #1;
    chk("R10", dma_req, 1'b1, "no change before edge");
    @(negedge clk); fifo_wr = 0;
    chk("R5", dma_req, 1'b0, "closes after 8th write");
    reads(4);   chk("R6", dma_req, 1'b0, "level 4 above mark");
    reads(1);   chk("R6", dma_req, 1'b1, "reopens at mark 3");
    writes(4); reads(2); writes(3);
    chk("R5", dma_req, 1'b1, "reads do not close burst");
    writes(1);  chk("R5", dma_req, 1'b0, "closes after 8 writes with reads mixed");
  endtask

  task automatic t_disable;
    do_reset(1, 1, 3, 8);
    cyc(0, 0);  writes(3);
    chk("R4", dma_req, 1'b1, "open mid burst");
    dma_en = 0; cyc(0, 0);
    chk("R9", dma_req, 1'b0, "disable drops request");
    dma_en = 1; cyc(0, 0);
    chk("R9", dma_req, 1'b1, "reopens at level 3");
    writes(7);  chk("R9", dma_req, 1'b1, "count restarted after disable");
    writes(1);  chk("R9", dma_req, 1'b0, "full burst closes");
  endtask

  task automatic t_space;
    do_reset(0, 1, 3, 8);
    cyc(0, 0);  writes(56);
    chk("R7", dma_req, 1'b1, "free 8 >= 8");
    writes(1);  chk("R7", dma_req, 1'b0, "free 7 < 8");
    reads(1);   chk("R7", dma_req, 1'b1, "free back to 8");
  endtask

  task automatic t_fallback;
    do_reset(1, 1, 5, 60);
    cyc(0, 0);  writes(4);
    chk("R8", dma_req, 1'b1, "over capacity: free 60");
    writes(1);  chk("R8", dma_req, 1'b0, "over capacity: level 5 closes like space mode");
    do_reset(1, 1, 4, 60);
    cyc(0, 0);  writes(5);
    chk("R3", dma_req, 1'b1, "sum equals depth: burst held");
    writes(54); chk("R3", dma_req, 1'b1, "59 writes still open");
    writes(1);  chk("R3", dma_req, 1'b0, "60th write closes");
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FIFO-DMA FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_level_tracking();
    t_burst();
    t_disable();
    t_space();
    t_fallback();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule